// File: doc/BRIEF.md
# Digital Potentiometer Command Engine

This block sits behind a two-wire serial slave front end and carries out the register commands of a dual digital potentiometer. Each pot has a wiper counter register, which sets the live tap position, and a bank of four data registers that model nonvolatile storage. The front end passes in the instruction byte and, for write commands, the data byte that follows it. It also signals the stop condition. The engine decodes the command and performs the operation:

- a read or write of a wiper register,
- a read or write of a data register,
- a single-pot transfer between a data register and its wiper register,
- a global transfer that acts on every pot at once.

For read commands the engine returns the selected byte one cycle after the instruction, so the front end can shift it out. A command that changes nonvolatile storage starts a timed busy period when the stop condition arrives. While busy, the engine takes no commands, so the front end withholds its acknowledge and the master can poll until the engine is free again. The increment/decrement opcode only sets a per-pot enable latch for an external stepping interface.

The data registers are not cleared by reset. On each reset release, every wiper register loads the value of data register 0 of its own pot.

Top module: `dpot_cmd_engine`

## Requirements
- R1: After reset is released, `wiper_o` byte k equals data register 0 of pot k within two clock cycles. `busy_o` and `incdec_en_o` are 0, and the data registers keep their contents across the reset.
- R2: The instruction byte is laid out as `{opcode[3:0], reg_sel[1:0], 1'b0, pot}`, with the opcode in bits 7:4, the data register select in bits 3:2 and the pot select in bit 0. Opcode 1001 makes `rd_valid_o` pulse for one cycle, on the cycle after the instruction. In that cycle `rd_data_o` carries the wiper register of the selected pot.
- R3: Opcode 1010 writes the next data byte into the wiper register of the selected pot. Any further data byte before the next instruction or stop is ignored.
- R4: Opcode 1100 writes the next data byte into data register `reg_sel` of the selected pot. Opcode 1011 returns that register with the same timing as R2.
- R5: Opcode 1101 copies data register `reg_sel` of the selected pot into that pot's wiper register. Opcode 1110 copies the pot's wiper register into its data register `reg_sel`. Neither opcode takes a data byte.
- R6: Opcode 0001 copies data register `reg_sel` into the wiper register for every pot at once. Opcode 1000 copies every wiper register into data register `reg_sel` of its own pot. Both ignore bit 0.
- R7: A stop that follows a completed 1100, 1110 or 1000 command raises `busy_o` on the next cycle, for exactly `BUSY_CYCLES` cycles. A stop after any other command leaves `busy_o` at 0.
- R8: While `busy_o` is 1, instruction and data bytes are ignored. No read is returned and no register changes.
- R9: Opcode 0010 sets only bit `pot` of `incdec_en_o`. The bit clears on a stop or on the next accepted instruction.
- R10: Opcodes not listed above change no register, return no read data and start no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | One-cycle strobe: instruction byte received |
| instr_i | input | 8 | Instruction byte |
| data_valid_i | input | 1 | One-cycle strobe: data byte received from master |
| data_i | input | DW | Data byte |
| stop_i | input | 1 | One-cycle strobe: stop condition seen |
| rd_valid_o | output | 1 | Read data valid strobe |
| rd_data_o | output | DW | Read data for the front end to shift out |
| busy_o | output | 1 | Nonvolatile write in progress |
| wiper_o | output | NUM_POTS*DW | Wiper registers, pot k at bits k*DW +: DW |
| incdec_en_o | output | NUM_POTS | Increment/decrement enable latch per pot |

## Verification
The assertions assume the front end produces each strobe for a single cycle. They also assume it never raises an instruction, a data byte and a stop in the same cycle, and that it sends data bytes only after an instruction. The checks on busy length and on frozen state rely on `stop_i` being the only source of a busy start. The bench keeps to these assumptions by driving every byte and stop through tasks that pulse one strobe for one cycle at a falling edge. It also sends each data byte after its instruction and waits for `busy_o` to fall before issuing a command it expects to run.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  localparam logic [3:0] OPC_RD_WCR   = 4'b1001;
  localparam logic [3:0] OPC_WR_WCR   = 4'b1010;
  localparam logic [3:0] OPC_RD_DR    = 4'b1011;
  localparam logic [3:0] OPC_WR_DR    = 4'b1100;
  localparam logic [3:0] OPC_DR2WCR   = 4'b1101;
  localparam logic [3:0] OPC_WCR2DR   = 4'b1110;
  localparam logic [3:0] OPC_G_DR2WCR = 4'b0001;
  localparam logic [3:0] OPC_G_WCR2DR = 4'b1000;
  localparam logic [3:0] OPC_INCDEC   = 4'b0010;

  typedef struct packed {
    logic rd_wcr;
    logic rd_dr;
    logic wr_wcr;
    logic wr_dr;
    logic dr2wcr;
    logic wcr2dr;
    logic glob;
    logic incdec;
    logic nv_now;   // nonvolatile op complete at instruction time
  } cmd_dec_t;
endpackage

// File: rtl/dpot_decode.sv
module dpot_decode
  import dpot_pkg::*;
(
  input  logic [3:0] opc_i,
  output cmd_dec_t   dec_o
);
  always_comb begin
    dec_o = '0;
    case (opc_i)
      OPC_RD_WCR:   dec_o.rd_wcr = 1'b1;
      OPC_WR_WCR:   dec_o.wr_wcr = 1'b1;
      OPC_RD_DR:    dec_o.rd_dr  = 1'b1;
      OPC_WR_DR:    dec_o.wr_dr  = 1'b1;
      OPC_DR2WCR:   dec_o.dr2wcr = 1'b1;
      OPC_WCR2DR: begin
        dec_o.wcr2dr = 1'b1;
        dec_o.nv_now = 1'b1;
      end
      OPC_G_DR2WCR: begin
        dec_o.dr2wcr = 1'b1;
        dec_o.glob   = 1'b1;
      end
      OPC_G_WCR2DR: begin
        dec_o.wcr2dr = 1'b1;
        dec_o.glob   = 1'b1;
        dec_o.nv_now = 1'b1;
      end
      OPC_INCDEC:   dec_o.incdec = 1'b1;
      default:      dec_o = '0;
    endcase
  end
endmodule

// File: rtl/dpot_pot_regs.sv
module dpot_pot_regs #(
  parameter int DW     = 8,
  parameter int NUM_DR = 4,
  localparam int SEL_W = $clog2(NUM_DR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wcr_we_i,
  input  logic [DW-1:0]    wcr_d_i,
  input  logic             dr_we_i,
  input  logic [SEL_W-1:0] dr_idx_i,
  input  logic [DW-1:0]    dr_d_i,
  output logic [DW-1:0]    wcr_o,
  output logic [DW-1:0]    dr_sel_o,
  output logic [DW-1:0]    dr0_o
);
  logic [DW-1:0] dr_q [NUM_DR];

  // Data registers model nonvolatile storage: untouched by reset
  always_ff @(posedge clk_i) begin
    if (dr_we_i) dr_q[dr_idx_i] <= dr_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wcr_o <= '0;
    else if (wcr_we_i) wcr_o <= wcr_d_i;
  end

  assign dr_sel_o = dr_q[dr_idx_i];
  assign dr0_o    = dr_q[0];
endmodule

// File: rtl/dpot_busy_timer.sv
module dpot_busy_timer #(
  parameter int BUSY_CYCLES = 250000,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CNT_W'(BUSY_CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/dpot_cmd_engine.sv
module dpot_cmd_engine
  import dpot_pkg::*;
#(
  parameter int NUM_POTS    = 2,
  parameter int DW          = 8,
  parameter int NUM_DR      = 4,
  parameter int BUSY_CYCLES = 250000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   instr_valid_i,
  input  logic [7:0]             instr_i,
  input  logic                   data_valid_i,
  input  logic [DW-1:0]          data_i,
  input  logic                   stop_i,
  output logic                   rd_valid_o,
  output logic [DW-1:0]          rd_data_o,
  output logic                   busy_o,
  output logic [NUM_POTS*DW-1:0] wiper_o,
  output logic [NUM_POTS-1:0]    incdec_en_o
);
  localparam int SEL_W = $clog2(NUM_DR);
  localparam int POT_W = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1;

  cmd_dec_t         dec_in, dec_q;
  logic [SEL_W-1:0] sel_q, sel_now;
  logic [POT_W-1:0] pot_q, pot_now;
  logic             init_ld_q, wr_arm_q, nv_pend_q;
  logic             instr_fire, data_fire, busy_start;

  logic [NUM_POTS-1:0] wcr_we, dr_we;
  logic [DW-1:0]       wcr_d  [NUM_POTS];
  logic [DW-1:0]       dr_d   [NUM_POTS];
  logic [DW-1:0]       wcr_q  [NUM_POTS];
  logic [DW-1:0]       dr_sel [NUM_POTS];
  logic [DW-1:0]       dr0    [NUM_POTS];
  logic [DW-1:0]       rd_src;

  dpot_decode u_dec (.opc_i(instr_i[7:4]), .dec_o(dec_in));

  assign instr_fire = instr_valid_i & ~busy_o & ~init_ld_q;
  assign data_fire  = data_valid_i  & ~busy_o & ~init_ld_q & wr_arm_q;
  assign sel_now    = instr_fire ? instr_i[2 +: SEL_W] : sel_q;
  assign pot_now    = instr_fire ? instr_i[0 +: POT_W] : pot_q;
  assign busy_start = stop_i & nv_pend_q & ~busy_o;

  for (genvar p = 0; p < NUM_POTS; p++) begin : g_pot
    logic hit;
    assign hit = (pot_now == POT_W'(p));

    assign wcr_we[p] = init_ld_q
                     | (data_fire  & dec_q.wr_wcr  & hit)
                     | (instr_fire & dec_in.dr2wcr & (dec_in.glob | hit));
    assign wcr_d[p]  = init_ld_q ? dr0[p] : (data_fire ? data_i : dr_sel[p]);
    assign dr_we[p]  = (data_fire  & dec_q.wr_dr   & hit)
                     | (instr_fire & dec_in.wcr2dr & (dec_in.glob | hit));
    assign dr_d[p]   = data_fire ? data_i : wcr_q[p];

    dpot_pot_regs #(.DW(DW), .NUM_DR(NUM_DR)) u_regs (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wcr_we_i (wcr_we[p]),
      .wcr_d_i  (wcr_d[p]),
      .dr_we_i  (dr_we[p]),
      .dr_idx_i (sel_now),
      .dr_d_i   (dr_d[p]),
      .wcr_o    (wcr_q[p]),
      .dr_sel_o (dr_sel[p]),
      .dr0_o    (dr0[p])
    );

    assign wiper_o[p*DW +: DW] = wcr_q[p];
  end

  assign rd_src = dec_in.rd_wcr ? wcr_q[pot_now] : dr_sel[pot_now];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_ld_q   <= 1'b1;
      wr_arm_q    <= 1'b0;
      nv_pend_q   <= 1'b0;
      dec_q       <= '0;
      sel_q       <= '0;
      pot_q       <= '0;
      incdec_en_o <= '0;
      rd_valid_o  <= 1'b0;
      rd_data_o   <= '0;
    end else begin
      init_ld_q  <= 1'b0;
      rd_valid_o <= 1'b0;
      if (instr_fire) begin
        dec_q      <= dec_in;
        sel_q      <= sel_now;
        pot_q      <= pot_now;
        wr_arm_q   <= dec_in.wr_wcr | dec_in.wr_dr;
        nv_pend_q  <= dec_in.nv_now;
        rd_valid_o <= dec_in.rd_wcr | dec_in.rd_dr;
        if (dec_in.rd_wcr | dec_in.rd_dr) rd_data_o <= rd_src;
        for (int p = 0; p < NUM_POTS; p++)
          incdec_en_o[p] <= dec_in.incdec & (pot_now == POT_W'(p));
      end else if (data_fire) begin
        wr_arm_q <= 1'b0;
        if (dec_q.wr_dr) nv_pend_q <= 1'b1;
      end
      if (stop_i) begin
        wr_arm_q    <= 1'b0;
        nv_pend_q   <= 1'b0;
        incdec_en_o <= '0;
      end
    end
  end

  dpot_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (busy_start),
    .busy_o  (busy_o)
  );
endmodule

// File: rtl/dpot_cmd_engine_chk.sv
module dpot_cmd_engine_chk #(
  parameter int NUM_POTS    = 2,
  parameter int DW          = 8,
  parameter int BUSY_CYCLES = 250000
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   instr_valid_i,
  input logic                   stop_i,
  input logic                   rd_valid_o,
  input logic                   busy_o,
  input logic [NUM_POTS*DW-1:0] wiper_o,
  input logic [NUM_POTS-1:0]    incdec_en_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (busy_o) run_q <= run_q + 1;
    else             run_q <= '0;
  end

  AST_RD_FROM_INSTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(instr_valid_i));                           // R2
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i));                               // R7
  AST_BUSY_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_q == BUSY_CYCLES));                      // R7
  AST_FROZEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(wiper_o));                                   // R8
  AST_NO_READ_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !rd_valid_o);                                        // R8
  AST_INCDEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(incdec_en_o));                                         // R9
  AST_INCDEC_STOP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (incdec_en_o == '0));                                // R9
endmodule

bind dpot_cmd_engine dpot_cmd_engine_chk #(
  .NUM_POTS(NUM_POTS), .DW(DW), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (.*);

// File: tb/sim_dpot_cmd_engine.sv
module sim_dpot_cmd_engine;
  localparam int BUSY = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       instr_valid = 1'b0, data_valid = 1'b0, stop = 1'b0;
  logic [7:0] instr = '0, data = '0;
  logic       rd_valid, busy;
  logic [7:0] rd_data;
  logic [15:0] wiper;
  logic [1:0] incdec;

  int checks = 0, fails = 0;
  logic [7:0] dr_m [2][4];
  logic [7:0] wcr_m [2];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  dpot_cmd_engine #(.BUSY_CYCLES(BUSY)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .instr_valid_i(instr_valid), .instr_i(instr),
    .data_valid_i(data_valid), .data_i(data), .stop_i(stop),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .busy_o(busy),
    .wiper_o(wiper), .incdec_en_o(incdec)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", "unexpected read strobe", 32'(rd_data), 32'hx);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, "read data", 32'(rd_data), 32'(e));
      end
    end
  end

  function automatic logic [7:0] ib(input logic [3:0] op, input int r, input int p);
    return {op, 2'(r), 1'b0, 1'(p)};
  endfunction

  task automatic send_instr(input logic [7:0] b);
    @(negedge clk); instr = b; instr_valid = 1'b1;
    @(negedge clk); instr_valid = 1'b0;
  endtask

  task automatic send_data(input logic [7:0] b);
    @(negedge clk); data = b; data_valid = 1'b1;
    @(negedge clk); data_valid = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); stop = 1'b1;
    @(negedge clk); stop = 1'b0;
  endtask

  task automatic wait_busy(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr_dr(input int p, input int r, input logic [7:0] v);
    int n;
    send_instr(ib(4'b1100, r, p));
    send_data(v);
    send_stop();
    dr_m[p][r] = v;
    wait_busy(n);
    check(n == BUSY, "R7", "busy length after data register write", 32'(n), 32'(BUSY));
  endtask

  task automatic rd_dr(input int p, input int r, input string t);
    exp_q.push_back(dr_m[p][r]); tag_q.push_back(t);
    send_instr(ib(4'b1011, r, p));
    @(negedge clk);
    send_stop();
  endtask

  task automatic rd_wcr(input int p, input string t);
    exp_q.push_back(wcr_m[p]); tag_q.push_back(t);
    send_instr(ib(4'b1001, 0, p));
    @(negedge clk);
    send_stop();
  endtask

  task automatic chk_wiper(input string t);
    check(wiper === {wcr_m[1], wcr_m[0]}, t, "wiper_o", 32'(wiper), 32'({wcr_m[1], wcr_m[0]}));
  endtask

  initial begin
    int n;
    logic [15:0] snap;
    do_reset();
    // Load every data register (R4, R7)
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++)
        wr_dr(p, r, 8'(8'h11 * (r + 1) + 8'h80 * p));

    // R1: wipers reload from data register 0, storage kept
    do_reset();
    wcr_m[0] = dr_m[0][0]; wcr_m[1] = dr_m[1][0];
    chk_wiper("R1");
    check(busy === 1'b0, "R1", "busy after reset", 32'(busy), 0);
    check(incdec === 2'b00, "R1", "incdec after reset", 32'(incdec), 0);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) rd_dr(p, r, "R4");

    // R3: wiper write, extra byte ignored, no busy
    send_instr(ib(4'b1010, 0, 1));
    send_data(8'h5A);
    send_data(8'hFF);
    send_stop();
    wcr_m[1] = 8'h5A;
    check(busy === 1'b0, "R7", "no busy after wiper write", 32'(busy), 0);
    chk_wiper("R3");
    rd_wcr(1, "R3");
    rd_wcr(0, "R2");

    // R5: single transfers
    send_instr(ib(4'b1101, 2, 0));
    send_stop();
    wcr_m[0] = dr_m[0][2];
    chk_wiper("R5");
    send_instr(ib(4'b1110, 3, 1));
    send_stop();
    dr_m[1][3] = wcr_m[1];
    wait_busy(n);
    check(n == BUSY, "R7", "busy length after single wiper-to-data", 32'(n), 32'(BUSY));
    rd_dr(1, 3, "R5");
    rd_dr(0, 3, "R5");

    // R6: global transfers, bit 0 set and ignored
    send_instr(ib(4'b0001, 1, 1));
    send_stop();
    wcr_m[0] = dr_m[0][1]; wcr_m[1] = dr_m[1][1];
    chk_wiper("R6");
    send_instr(ib(4'b1010, 0, 0));
    send_data(8'h77);
    send_stop();
    wcr_m[0] = 8'h77;
    send_instr(ib(4'b1000, 0, 1));
    send_stop();
    dr_m[0][0] = wcr_m[0]; dr_m[1][0] = wcr_m[1];
    wait_busy(n);
    check(n == BUSY, "R7", "busy length after global wiper-to-data", 32'(n), 32'(BUSY));
    rd_dr(0, 0, "R6");
    rd_dr(1, 0, "R6");

    // R8: commands during busy ignored
    wr_dr(0, 1, 8'h3C);
    send_instr(ib(4'b1100, 2, 1));
    send_data(8'hC3);
    send_stop();
    dr_m[1][2] = 8'hC3;
    check(busy === 1'b1, "R7", "busy raised after stop", 32'(busy), 1);
    snap = wiper;
    send_instr(ib(4'b1001, 0, 0));
    check(rd_valid === 1'b0, "R8", "read strobe while busy", 32'(rd_valid), 0);
    send_instr(ib(4'b1010, 0, 0));
    send_data(8'hEE);
    check(wiper === snap, "R8", "wiper write while busy", 32'(wiper), 32'(snap));
    send_instr(ib(4'b1101, 1, 1));
    check(wiper === snap, "R8", "transfer while busy", 32'(wiper), 32'(snap));
    wait_busy(n);
    chk_wiper("R8");
    rd_dr(1, 2, "R8");

    // R9: increment/decrement enable latch
    send_instr(ib(4'b0010, 0, 1));
    check(incdec === 2'b10, "R9", "latch set pot1", 32'(incdec), 2);
    rd_wcr(0, "R9");
    check(incdec === 2'b00, "R9", "latch clear on next instruction", 32'(incdec), 0);
    send_instr(ib(4'b0010, 0, 0));
    check(incdec === 2'b01, "R9", "latch set pot0", 32'(incdec), 1);
    send_stop();
    check(incdec === 2'b00, "R9", "latch clear on stop", 32'(incdec), 0);

    // R10: undefined opcodes
    send_instr(ib(4'b0101, 1, 0));
    send_data(8'h99);
    send_stop();
    send_instr(ib(4'b1111, 2, 1));
    send_data(8'h66);
    send_stop();
    check(busy === 1'b0, "R10", "no busy after undefined opcode", 32'(busy), 0);
    chk_wiper("R10");
    rd_dr(0, 1, "R10");
    rd_dr(1, 2, "R10");
    rd_wcr(1, "R10");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2", "outstanding expected reads", 32'(exp_q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule